// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is the host side of a three-wire link to a slow delta-sigma converter. On a `start` pulse it pulls chip select low. It waits a programmable settling time and then watches the data line, which the converter holds high while a conversion is still running. The reader sends no serial clock while that line is high. When the line drops, the reader sends exactly 32 serial clock pulses and captures one bit on each rising edge. It then releases chip select at the falling edge of the 32nd pulse, which tells the converter to begin its next conversion.

The captured word is split into the end-of-conversion flag, the sign, the extended-range flag, a 24-bit result and four sub-LSB bits. A frame-error flag reports status combinations that a healthy converter cannot produce. A one-cycle `frameValid` pulse marks each new set of fields. If the converter never finishes, a poll limit releases chip select and raises a one-cycle `timeout` pulse. The data input is assumed synchronous to `clk`.

Top module: `sdfr_reader`

## Requirements
- R1: After reset, `adcCsN` is 1, `adcSck` is 0, and `frameValid` and `timeout` are 0. `adcSck` is 0 in every cycle in which `adcCsN` is 1.
- R2: While the reader is idle, a `start` pulse drives `adcCsN` low on the next edge. The reader then waits `settleCycles`+1 cycles before it polls. `adcCsN` returns high on the same edge on which `adcSck` makes its 32nd fall.
- R3: While polling, `adcSck` stays low for as long as `adcSdo` reads 1. Clocking begins once a 0 is sampled.
- R4: Each transaction has exactly 32 `adcSck` rising edges, and one `adcSdo` bit is captured per rising edge, most significant first. The field layout is:
  - bit 31 is `eocBit`;
  - bit 30 is a dummy bit;
  - bit 29 is `signBit` (1 means zero or positive);
  - bit 28 is `extRange`;
  - bits 27:4 are `result`;
  - bits 3:0 are `subLsb`.
- R5: `frameValid` is a one-cycle pulse on the edge where the fields update. The fields hold their values in every other cycle.
- R6: Each `adcSck` half-period lasts `divHalf` cycles. Values of `divHalf` below 2 act as 2.
- R7: `frameErr` = dummy bit | (`signBit`==0 & `extRange`==0 & `result`!=0).
- R8: If `adcSdo` is still 1 after `pollLimit`+1 poll samples, `adcCsN` rises and `timeout` pulses for one cycle. There is no `frameValid` pulse and the fields are unchanged.
- R9: A `start` pulse while a transaction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one read transaction |
| divHalf | input | DIV_W | Serial clock half-period in system cycles |
| settleCycles | input | CNT_W | Wait after chip select falls, before polling |
| pollLimit | input | CNT_W | Poll samples allowed beyond the first |
| adcSdo | input | 1 | Serial data from the converter |
| adcCsN | output | 1 | Chip select, active low |
| adcSck | output | 1 | Serial clock, idles low |
| frameValid | output | 1 | One-cycle pulse: new fields |
| eocBit | output | 1 | Captured end-of-conversion bit |
| signBit | output | 1 | Captured sign bit |
| extRange | output | 1 | Captured extended-range flag |
| result | output | 24 | Conversion result |
| subLsb | output | 4 | Bits below the result LSB |
| frameErr | output | 1 | Impossible status combination seen |
| timeout | output | 1 | One-cycle pulse: poll limit expired |

## Verification
The bench feeds the reader the following frames:
- a positive in-range code, which shows the field slicing and the bit order;
- an over-range code, sent at a slower clock with a long conversion delay, which shows that no pulses are sent while polling;
- a code with the dummy bit set and a negative-in-range code with a nonzero result, which must both raise the error flag;
- a negative extended-range code, which must not raise it;
- divider values of 0 and 1, which show the clamp.

A converter that never finishes exercises the timeout path. A second `start` sent in the middle of a frame shows that requests are not queued. A behavioural model predicts chip select, serial clock and both pulses in every cycle.

// File: rtl/sdfr_pkg.sv
package sdfr_pkg;
  localparam int FRAME_BITS = 32;
  localparam int RES_W      = 24;
  localparam int SUB_W      = 4;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  // bit positions fixed by the converter's frame order
  localparam int POS_EOC  = FRAME_BITS - 1;
  localparam int POS_DMY  = FRAME_BITS - 2;
  localparam int POS_SIGN = FRAME_BITS - 3;
  localparam int POS_EXT  = FRAME_BITS - 4;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SETTLE, ST_POLL, ST_SHIFT
  } sdfr_state_e;

  typedef struct packed {
    logic shiftEn;   // capture adcSdo on this rising serial edge
    logic latch;     // 32nd falling edge: publish fields
  } sdfr_strobe_t;
endpackage

// File: rtl/sdfr_clkdiv.sv
module sdfr_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divHalf,
  output logic             halfTick
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] halfCnt;

  assign effDiv   = (divHalf < MIN_DIV) ? MIN_DIV : divHalf;
  assign halfTick = run && (halfCnt == effDiv - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          halfCnt <= '0;
    else if (!run)      halfCnt <= '0;
    else if (halfTick)  halfCnt <= '0;
    else                halfCnt <= halfCnt + DIV_W'(1);
  end
endmodule

// File: rtl/sdfr_ctrl.sv
module sdfr_ctrl
  import sdfr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] settleCycles,
  input  logic [CNT_W-1:0] pollLimit,
  input  logic             adcSdo,
  input  logic             halfTick,
  output logic             clkRun,
  output logic             adcCsN,
  output logic             adcSck,
  output logic             timeoutPulse,
  output sdfr_strobe_t     stb
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  sdfr_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;

  assign clkRun      = (state == ST_SHIFT);
  assign stb.shiftEn = clkRun && halfTick && !adcSck;
  assign stb.latch   = clkRun && halfTick && adcSck && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      bitCnt       <= '0;
      adcCsN       <= 1'b1;
      adcSck       <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutPulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SETTLE;
            cnt    <= '0;
            adcCsN <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (cnt >= settleCycles) begin
            state <= ST_POLL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_POLL: begin
          if (!adcSdo) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
          end else if (cnt >= pollLimit) begin
            state        <= ST_IDLE;
            adcCsN       <= 1'b1;
            timeoutPulse <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (halfTick) begin
            adcSck <= ~adcSck;
            if (adcSck) begin
              if (bitCnt == LAST_BIT) begin
                state  <= ST_IDLE;
                adcCsN <= 1'b1;
              end else begin
                bitCnt <= bitCnt + BIT_W'(1);
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdfr_datapath.sv
module sdfr_datapath
  import sdfr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  sdfr_strobe_t     stb,
  input  logic             adcSdo,
  output logic             frameValid,
  output logic             eocBit,
  output logic             signBit,
  output logic             extRange,
  output logic [RES_W-1:0] result,
  output logic [SUB_W-1:0] subLsb,
  output logic             frameErr
);
  logic [FRAME_BITS-1:0] shiftReg;
  logic [RES_W-1:0]      nextRes;
  logic                  nextErr;

  assign nextRes = shiftReg[SUB_W +: RES_W];
  assign nextErr = shiftReg[POS_DMY]
                 | (~shiftReg[POS_SIGN] & ~shiftReg[POS_EXT] & (|nextRes));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {shiftReg[FRAME_BITS-2:0], adcSdo};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      eocBit     <= 1'b0;
      signBit    <= 1'b0;
      extRange   <= 1'b0;
      result     <= '0;
      subLsb     <= '0;
      frameErr   <= 1'b0;
    end else begin
      frameValid <= stb.latch;
      if (stb.latch) begin
        eocBit   <= shiftReg[POS_EOC];
        signBit  <= shiftReg[POS_SIGN];
        extRange <= shiftReg[POS_EXT];
        result   <= nextRes;
        subLsb   <= shiftReg[SUB_W-1:0];
        frameErr <= nextErr;
      end
    end
  end
endmodule

// File: rtl/sdfr_reader.sv
module sdfr_reader
  import sdfr_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] divHalf,
  input  logic [CNT_W-1:0] settleCycles,
  input  logic [CNT_W-1:0] pollLimit,
  input  logic             adcSdo,
  output logic             adcCsN,
  output logic             adcSck,
  output logic             frameValid,
  output logic             eocBit,
  output logic             signBit,
  output logic             extRange,
  output logic [23:0]      result,
  output logic [3:0]       subLsb,
  output logic             frameErr,
  output logic             timeout
);
  sdfr_strobe_t stb;
  logic         clkRun;
  logic         halfTick;

  sdfr_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rstN(rstN), .run(clkRun), .divHalf(divHalf), .halfTick(halfTick)
  );

  sdfr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .settleCycles(settleCycles),
    .pollLimit(pollLimit), .adcSdo(adcSdo), .halfTick(halfTick),
    .clkRun(clkRun), .adcCsN(adcCsN), .adcSck(adcSck),
    .timeoutPulse(timeout), .stb(stb)
  );

  sdfr_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .adcSdo(adcSdo),
    .frameValid(frameValid), .eocBit(eocBit), .signBit(signBit),
    .extRange(extRange), .result(result), .subLsb(subLsb), .frameErr(frameErr)
  );
endmodule

// File: rtl/sdfr_checker.sv
module sdfr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        adcCsN,
  input logic        adcSck,
  input logic        frameValid,
  input logic        timeout,
  input logic [23:0] result
);
  // R1: serial clock stays low whenever chip select is released
  a_r1_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    adcCsN |-> !adcSck);

  // R2: a published frame coincides with chip select rising
  a_r2_cs_release_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> $rose(adcCsN));

  // R5: valid is a single-cycle pulse
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  // R5: result changes only together with valid
  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> $stable(result));

  // R6: each serial clock level lasts at least two cycles
  a_r6_high_min: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcSck) |=> adcSck);
  a_r6_low_min: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcSck) |=> !adcSck);

  // R8: timeout is a single pulse with chip select released and no frame
  a_r8_timeout_release: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> ($rose(adcCsN) && !frameValid));
  a_r8_timeout_single: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> !timeout);
endmodule

bind sdfr_reader sdfr_checker u_sdfr_checker (
  .clk(clk), .rstN(rstN), .adcCsN(adcCsN), .adcSck(adcSck),
  .frameValid(frameValid), .timeout(timeout), .result(result)
);

// File: tb/tb_sdfr_reader.sv
`timescale 1ns/1ps
module tb_sdfr_reader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  divHalf = 8'd2;
  logic [15:0] settleCycles = 16'd3;
  logic [15:0] pollLimit = 16'd1000;
  logic        adcSdo = 1'b1;
  logic        adcCsN, adcSck, frameValid, eocBit, signBit, extRange, frameErr, timeout;
  logic [23:0] result;
  logic [3:0]  subLsb;

  always #4 clk = ~clk;

  sdfr_reader dut (
    .clk(clk), .rstN(rstN), .start(start), .divHalf(divHalf),
    .settleCycles(settleCycles), .pollLimit(pollLimit), .adcSdo(adcSdo),
    .adcCsN(adcCsN), .adcSck(adcSck), .frameValid(frameValid), .eocBit(eocBit),
    .signBit(signBit), .extRange(extRange), .result(result), .subLsb(subLsb),
    .frameErr(frameErr), .timeout(timeout)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural expectation of cs/sck/pulses ----------------
  int  mSt = 0, mCnt = 0, mHalf = 0, mBits = 0;
  bit  mSck = 0, mCs = 1, mValid = 0, mTo = 0;

  function automatic int effDiv();
    return (divHalf < 2) ? 2 : int'(divHalf);
  endfunction

  always @(posedge clk) begin
    mValid = 0; mTo = 0;
    if (!rstN) begin
      mSt = 0; mCnt = 0; mHalf = 0; mBits = 0; mSck = 0; mCs = 1;
    end else begin
      if (mSt == 0) begin
        if (start) begin mSt = 1; mCnt = 0; mCs = 0; end
      end else if (mSt == 1) begin
        if (mCnt >= int'(settleCycles)) begin mSt = 2; mCnt = 0; end
        else mCnt++;
      end else if (mSt == 2) begin
        if (adcSdo == 1'b0) begin mSt = 3; mBits = 0; mHalf = 0; end
        else if (mCnt >= int'(pollLimit)) begin mSt = 0; mCs = 1; mTo = 1; end
        else mCnt++;
      end else begin
        mHalf++;
        if (mHalf == effDiv()) begin
          mHalf = 0;
          if (!mSck) mSck = 1;
          else begin
            mSck = 0;
            if (mBits == 31) begin mSt = 0; mCs = 1; mValid = 1; end
            else mBits++;
          end
        end
      end
    end
  end

  // ---------------- converter model and per-cycle comparison ----------------
  logic [31:0] slvWord = 32'h0;
  int  slvDelay = 0;
  int  csCyc = 0, falls = 0, riseCnt = 0, firstRiseCyc = -1;
  int  hiRun = 0, lastHigh = 0;
  bit  prevSck = 0;

  always @(negedge clk) begin
    if (rstN) begin
      chk(adcCsN == mCs, "R2 cs", adcCsN, mCs);
      chk(adcSck == mSck, "R6 sck", adcSck, mSck);
      chk(frameValid == mValid, "R5 valid", frameValid, mValid);
      chk(timeout == mTo, "R8 timeout", timeout, mTo);
      chk(!(adcCsN && adcSck), "R1 sck idle", adcSck, 0);
    end
    if (adcSck && !prevSck) begin
      riseCnt++;
      if (firstRiseCyc < 0) firstRiseCyc = csCyc;
    end
    if (adcSck) hiRun++;
    else if (hiRun > 0) begin lastHigh = hiRun; hiRun = 0; end
    if (adcCsN) begin
      csCyc = 0; falls = 0; prevSck = 0; adcSdo = 1'b1;
    end else begin
      csCyc++;
      if (prevSck && !adcSck) falls++;
      prevSck = adcSck;
      if (falls == 0) adcSdo = (csCyc <= slvDelay) ? 1'b1 : slvWord[31];
      else if (falls < 32) adcSdo = slvWord[31-falls];
      else adcSdo = 1'b1;
    end
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(output bit gotValid, output bit gotTo);
    gotValid = 0; gotTo = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (frameValid) begin gotValid = 1; return; end
      if (timeout) begin gotTo = 1; return; end
    end
  endtask

  task automatic runFrame(input logic [31:0] w, input int delay, input logic [7:0] div, input string tag);
    bit v, t;
    logic exErr;
    slvWord = w; slvDelay = delay; divHalf = div;
    riseCnt = 0; firstRiseCyc = -1;
    pulseStart();
    waitDone(v, t);
    chk(v, {tag, " R2 frame done"}, v, 1);
    chk(adcCsN && !adcSck, {tag, " R2 cs high at end"}, {adcCsN, adcSck}, 2'b10);
    chk(riseCnt == 32, {tag, " R4 rise count"}, riseCnt, 32);
    chk(firstRiseCyc > delay, {tag, " R3 no clock while busy"}, firstRiseCyc, delay + 1);
    chk(lastHigh == effDiv(), {tag, " R6 half period"}, lastHigh, effDiv());
    chk(eocBit == w[31], {tag, " R4 eoc"}, eocBit, w[31]);
    chk(signBit == w[29], {tag, " R4 sign"}, signBit, w[29]);
    chk(extRange == w[28], {tag, " R4 ext"}, extRange, w[28]);
    chk(result == w[27:4], {tag, " R4 result"}, result, w[27:4]);
    chk(subLsb == w[3:0], {tag, " R4 sub"}, subLsb, w[3:0]);
    exErr = w[30] | (!w[29] && !w[28] && (w[27:4] != 0));
    chk(frameErr == exErr, {tag, " R7 error"}, frameErr, exErr);
    @(negedge clk);
    chk(!frameValid, {tag, " R5 pulse"}, frameValid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    bit v, t;
    logic [23:0] held;
    repeat (3) @(negedge clk);
    chk(adcCsN == 1 && adcSck == 0 && !frameValid && !timeout, "R1 reset",
        {adcCsN, adcSck, frameValid, timeout}, 4'b1000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(adcCsN == 1, "R1 idle after reset", adcCsN, 1);

    runFrame(32'h2ABC_DE15, 0,  8'd2, "positive");
    runFrame(32'h3000_0003, 40, 8'd5, "overrange");
    runFrame(32'h6123_4560, 5,  8'd3, "dummy");
    runFrame(32'h0FFF_FFF0, 2,  8'd2, "neg nonzero");
    runFrame(32'h1FFF_FFF2, 9,  8'd4, "neg extended");
    runFrame(32'h2000_0010, 0,  8'd0, "div zero");
    runFrame(32'h2800_0017, 3,  8'd1, "div one");

    // R8: converter never finishes
    held = result;
    pollLimit = 16'd20; slvDelay = 1000000; slvWord = 32'h2555_5555;
    pulseStart();
    waitDone(v, t);
    chk(t && !v, "R8 timeout seen", {t, v}, 2'b10);
    chk(adcCsN, "R8 cs released", adcCsN, 1);
    chk(result == held, "R8 fields unchanged", result, held);
    pollLimit = 16'd1000;

    // R9: start during a transaction is ignored
    slvWord = 32'h2123_4569; slvDelay = 0; divHalf = 8'd3;
    pulseStart();
    repeat (30) @(negedge clk);
    pulseStart();
    waitDone(v, t);
    chk(v && result == 24'h123456, "R9 frame intact", result, 24'h123456);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(adcCsN, "R9 no second transaction", adcCsN, 1);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule